// File: doc/BRIEF.md
# Flash Reset and Abort Sequencer

This block sits beside the control logic of an automated flash device and owns the active-low reset and power-down pin. It watches that pin through a synchroniser, together with a busy flag from the embedded program and erase engine. From these it drives four things: an output-driver enable, an abort request to the engine, and two qualifiers that say when a read may return valid data and when a write may be accepted.

With no operation running, a low pulse on the pin takes effect only once it has lasted a minimum number of clock cycles. The device then enters power-down: outputs are disabled and both qualifiers drop. If the pin goes low while the engine is busy, the operation is aborted at once and a fixed shutdown interval runs. When that interval ends, the block wakes directly if the pin is already high again. If the pin is still low, it parks in power-down. The read and write recovery delays are counted from the moment of wake-up. In the abort case that moment is the end of the shutdown interval, not the pin release.

Each wake-up emits a one-cycle initialisation pulse. The command decoder uses it to return to array-read mode, load its status register with 0x80 and lock every block. A one-cycle abort-done flag tells the decoder that data at the interrupted location or block can no longer be trusted. All delays are parameters counted in clock cycles.

Top module: `flash_rst_seq`

## Requirements
In this section, "cycle t" means the output value seen after the t-th rising edge. Edge 0 is the first edge that samples a new level on `pin_n`. A pin level is seen by the control logic two edges after it is sampled.
- R1: With `eng_busy` low, a low on `pin_n` sampled on MIN_LOW or more consecutive edges drops `out_en`, `rd_ok` and `wr_ok` in cycle MIN_LOW+1.
- R2: With `eng_busy` low, a low on `pin_n` sampled on fewer than MIN_LOW edges changes no output.
- R3: After power-down with the pin first sampled high again at edge L, `init_pulse` fires in cycle L+2, `out_en` returns in cycle L+2, and `rd_ok` rises in cycle L+2+RD_REC.
- R4: In the same case, `wr_ok` rises in cycle L+2+WR_REC.
- R5: A low on `pin_n` while `eng_busy` is high raises `abort_req` in cycle 2 for exactly ABORT_LEN cycles. `out_en`, `rd_ok` and `wr_ok` drop in cycle 2.
- R6: For an abort whose pin was low on L sampled edges, wake-up happens in cycle W = max(ABORT_LEN, L)+2. `rd_ok` rises in cycle W+RD_REC and `wr_ok` rises in cycle W+WR_REC.
- R7: After an abort, `abort_done` is high for exactly one cycle, cycle ABORT_LEN+2.
- R8: `init_pulse` (decoder to array-read mode, status 0x80, all blocks locked) is high for exactly one cycle on each wake-up, and never on an ignored pulse.
- R9: While `rst_n` is low, all outputs are low and the pin is taken as low. After release with the pin high, `rd_ok` rises in cycle 2+RD_REC, counting edge 0 as the first edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| pin_n | input | 1 | Asynchronous active-low reset/power-down pin |
| eng_busy | input | 1 | Program or erase engine is running |
| out_en | output | 1 | Output drivers enabled (low means high impedance) |
| abort_req | output | 1 | Tells the engine to abandon its operation |
| abort_done | output | 1 | One-cycle flag: aborted location or block is invalid |
| rd_ok | output | 1 | Read data may be flagged valid |
| wr_ok | output | 1 | Writes may be accepted |
| init_pulse | output | 1 | One-cycle decoder initialisation on wake-up |

## Verification
A wrong state register shows up at the ports within one cycle. Examples are a missed abort, a power-down entered too early, or a wake-up taken while the pin is still low. Each of these flips `out_en` or `abort_req` in a cycle the arithmetic says it must not. A wrong recovery or shutdown count moves the rising edge of `rd_ok` or `wr_ok`, or the `abort_done` pulse, by that many cycles. The sweeps over pulse length, with the engine idle and busy, locate each such shift to the exact cycle.

// File: rtl/frs_pkg.sv
// Package: shared state encoding for the flash reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package frs_pkg;
    typedef enum logic [1:0] {
        ST_DOWN  = 2'd0,   // power-down, outputs off
        ST_ABORT = 2'd1,   // shutdown interval after an aborted operation
        ST_WAKE  = 2'd2,   // recovery delays running
        ST_RUN   = 2'd3    // normal operation
    } frs_state_e;
endpackage

// File: rtl/frs_sync.sv
// Module: frs_sync
// Brings the asynchronous pin level into the clock domain through a chain
// of flops. Assumes STAGES >= 2. In reset the chain holds 0, which reads as
// a low (asserted) pin.
module frs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/frs_timer.sv
// Module: frs_timer
// Interval counter. It counts cycles while run is high and clears when run
// is low. last marks the LIMIT-th running cycle. done holds once LIMIT cycles
// have run. Assumes LIMIT >= 1.
module frs_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] CMAX = W'(LIMIT);
    localparam logic [W-1:0] CPRE = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count running cycles, saturating at LIMIT; clear whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == CPRE);
    assign done = (cnt == CMAX);
endmodule

// File: rtl/frs_fsm.sv
// Module: frs_fsm
// Control state machine of the reset sequencer. Decides abort, power-down,
// wake-up and run from the synchronised pin and the timer flags, and drives
// all port-level qualifiers. Assumes the timers are cleared when their run
// input drops.
module frs_fsm
    import frs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_lo,
    input  logic       eng_busy,
    input  logic       low_last,
    input  logic       abort_last,
    input  logic [1:0] rec_done,
    output logic       low_run,
    output logic       abort_run,
    output logic       wake_run,
    output logic       out_en,
    output logic       abort_req,
    output logic       abort_done,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       init_pulse
);
    frs_state_e state, nxt;
    logic       done_q, init_q;

    // Next-state decision from the pin, the busy flag and the timer flags.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN, ST_WAKE: begin
                if (state == ST_RUN && pin_lo && eng_busy) begin
                    nxt = ST_ABORT;
                end else if (low_last) begin
                    nxt = ST_DOWN;
                end else if (state == ST_WAKE && (&rec_done)) begin
                    nxt = ST_RUN;
                end
            end
            ST_ABORT: begin
                if (abort_last) begin
                    nxt = pin_lo ? ST_DOWN : ST_WAKE;
                end
            end
            ST_DOWN: begin
                if (!pin_lo) begin
                    nxt = ST_WAKE;
                end
            end
            default: nxt = ST_DOWN;
        endcase
    end

    // State register plus the two one-cycle event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_DOWN;
            done_q <= 1'b0;
            init_q <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= (state == ST_ABORT) && abort_last;
            init_q <= (nxt == ST_WAKE) && (state != ST_WAKE);
        end
    end

    // Timer enables and port qualifiers decoded from the current state.
    always_comb begin
        low_run    = (state == ST_RUN || state == ST_WAKE) && pin_lo;
        abort_run  = (state == ST_ABORT);
        wake_run   = (state == ST_WAKE);
        out_en     = (state == ST_RUN) || (state == ST_WAKE);
        abort_req  = (state == ST_ABORT);
        rd_ok      = (state == ST_RUN) || (state == ST_WAKE && rec_done[0]);
        wr_ok      = (state == ST_RUN) || (state == ST_WAKE && rec_done[1]);
        abort_done = done_q;
        init_pulse = init_q;
    end

    AST_ABORT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_req) |-> $past(eng_busy && pin_lo));                        // R5
    AST_DONE_CLOSES_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |-> ($past(abort_req) && !abort_req));                       // R7
    AST_INIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);                                            // R8
    AST_WAKE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && $past(state) == ST_DOWN) |-> $past(!pin_lo));     // R3
    AST_RD_RISES_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ok) |-> ($past(state) == ST_WAKE));                           // R3
    AST_WR_RISES_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ok) |-> ($past(state) == ST_WAKE));                           // R4
    AST_QUALS_OFF_IN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (!rd_ok && !wr_ok && !out_en));                          // R5
endmodule

// File: rtl/flash_rst_seq.sv
// Module: flash_rst_seq (top)
// Reset/power-down and abort sequencer for an automated flash device.
// Parts: a pin synchroniser, a minimum-width timer, an abort shutdown timer,
// two recovery timers (read, write) and the control FSM.
// Assumes: MIN_LOW, ABORT_LEN, RD_REC and WR_REC >= 1; SYNC_STAGES >= 2.
module flash_rst_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 4,
    parameter int ABORT_LEN   = 6,
    parameter int RD_REC      = 3,
    parameter int WR_REC      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic eng_busy,
    output logic out_en,
    output logic abort_req,
    output logic abort_done,
    output logic rd_ok,
    output logic wr_ok,
    output logic init_pulse
);
    localparam int NREC = 2;
    localparam int REC_LEN [NREC] = '{RD_REC, WR_REC};

    logic            pin_s, pin_lo;
    logic            low_run, low_last, low_done;
    logic            abort_run, abort_last, abort_full;
    logic            wake_run;
    logic [NREC-1:0] rec_done;
    logic [NREC-1:0] rec_last;

    frs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_s)
    );
    assign pin_lo = !pin_s;

    frs_timer #(.LIMIT(MIN_LOW)) u_low_tmr (
        .clk(clk), .rst_n(rst_n), .run(low_run), .last(low_last), .done(low_done)
    );

    frs_timer #(.LIMIT(ABORT_LEN)) u_abort_tmr (
        .clk(clk), .rst_n(rst_n), .run(abort_run), .last(abort_last), .done(abort_full)
    );

    // One recovery timer per qualifier: index 0 reads, index 1 writes.
    for (genvar i = 0; i < NREC; i++) begin : g_rec
        frs_timer #(.LIMIT(REC_LEN[i])) u_rec_tmr (
            .clk(clk), .rst_n(rst_n), .run(wake_run),
            .last(rec_last[i]), .done(rec_done[i])
        );
    end

    frs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pin_lo(pin_lo), .eng_busy(eng_busy),
        .low_last(low_last), .abort_last(abort_last), .rec_done(rec_done),
        .low_run(low_run), .abort_run(abort_run), .wake_run(wake_run),
        .out_en(out_en), .abort_req(abort_req), .abort_done(abort_done),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .init_pulse(init_pulse)
    );

    AST_MIN_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_en) && !abort_req |-> $past(pin_lo));                        // R1
    AST_ABORT_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        abort_full |-> !abort_req);                                             // R5
    AST_LOW_IDLE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        low_done |-> !out_en);                                                  // R1
    AST_REC_LAST_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rec_last) |-> (out_en && !abort_req));                                // R3
endmodule

// File: tb/flash_rst_seq_test.sv
module flash_rst_seq_test;
    localparam int ML = 3;
    localparam int AL = 4;
    localparam int RD = 2;
    localparam int WR = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1;
    logic eng_busy = 1'b0;
    logic out_en, abort_req, abort_done, rd_ok, wr_ok, init_pulse;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    flash_rst_seq #(
        .SYNC_STAGES(2), .MIN_LOW(ML), .ABORT_LEN(AL), .RD_REC(RD), .WR_REC(WR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .eng_busy(eng_busy),
        .out_en(out_en), .abort_req(abort_req), .abort_done(abort_done),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .init_pulse(init_pulse)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one low pulse of L sampled edges; record the port timeline.
    task automatic pulse(input int L, input bit busy);
        int out_low_first = -1, rd_low = 0, rd_rise = -1, wr_rise = -1;
        int init_t = -1, init_cnt = 0, ab_first = -1, ab_cnt = 0;
        int done_t = -1, done_cnt = 0, outen_back = -1;
        bit rd_seen_low = 0, wr_seen_low = 0, out_seen_low = 0;
        int tmax = L + AL + WR + 12;
        int w;
        pin_n = 1'b0;
        eng_busy = busy;
        for (int t = 0; t <= tmax; t++) begin
            @(posedge clk);
            @(negedge clk);
            if (!out_en && out_low_first < 0) out_low_first = t;
            if (!out_en) out_seen_low = 1;
            if (out_en && out_seen_low && outen_back < 0) outen_back = t;
            if (!rd_ok) begin rd_low++; rd_seen_low = 1; end
            if (!wr_ok) wr_seen_low = 1;
            if (rd_ok && rd_seen_low && rd_rise < 0) rd_rise = t;
            if (wr_ok && wr_seen_low && wr_rise < 0) wr_rise = t;
            if (init_pulse) begin init_cnt++; if (init_t < 0) init_t = t; end
            if (abort_req) begin ab_cnt++; if (ab_first < 0) ab_first = t; end
            if (abort_done) begin done_cnt++; if (done_t < 0) done_t = t; end
            if (t == L - 1) pin_n = 1'b1;
            if (abort_req) eng_busy = 1'b0;
        end
        if (!busy && L < ML) begin
            chk("R2", $sformatf("L=%0d out_en low cycles", L), out_seen_low, 0);
            chk("R2", $sformatf("L=%0d rd_ok low cycles", L), rd_low, 0);
            chk("R2", $sformatf("L=%0d wr_ok dropped", L), wr_seen_low, 0);
            chk("R8", $sformatf("L=%0d init pulses", L), init_cnt, 0);
        end else if (!busy) begin
            chk("R1", $sformatf("L=%0d out_en fall", L), out_low_first, ML + 1);
            chk("R1", $sformatf("L=%0d abort_req count", L), ab_cnt, 0);
            chk("R3", $sformatf("L=%0d out_en back", L), outen_back, L + 2);
            chk("R3", $sformatf("L=%0d rd_ok rise", L), rd_rise, L + 2 + RD);
            chk("R4", $sformatf("L=%0d wr_ok rise", L), wr_rise, L + 2 + WR);
            chk("R8", $sformatf("L=%0d init time", L), init_t, L + 2);
            chk("R8", $sformatf("L=%0d init count", L), init_cnt, 1);
        end else begin
            w = ((AL > L) ? AL : L) + 2;
            chk("R5", $sformatf("L=%0d abort first", L), ab_first, 2);
            chk("R5", $sformatf("L=%0d abort length", L), ab_cnt, AL);
            chk("R5", $sformatf("L=%0d out_en fall", L), out_low_first, 2);
            chk("R7", $sformatf("L=%0d abort_done time", L), done_t, AL + 2);
            chk("R7", $sformatf("L=%0d abort_done count", L), done_cnt, 1);
            chk("R6", $sformatf("L=%0d wake (init) time", L), init_t, w);
            chk("R6", $sformatf("L=%0d rd_ok rise", L), rd_rise, w + RD);
            chk("R6", $sformatf("L=%0d wr_ok rise", L), wr_rise, w + WR);
            chk("R8", $sformatf("L=%0d init count", L), init_cnt, 1);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int rd_rise;
        repeat (3) @(negedge clk);
        // R9: reset state of every output
        chk("R9", "out_en in reset", int'(out_en), 0);
        chk("R9", "rd_ok in reset", int'(rd_ok), 0);
        chk("R9", "wr_ok in reset", int'(wr_ok), 0);
        chk("R9", "abort_req in reset", int'(abort_req), 0);
        chk("R9", "init_pulse in reset", int'(init_pulse), 0);
        rst_n = 1'b1;
        rd_rise = -1;
        for (int t = 0; t < 20; t++) begin
            @(posedge clk);
            @(negedge clk);
            if (rd_ok && rd_rise < 0) rd_rise = t;
        end
        chk("R9", "rd_ok rise after reset", rd_rise, 2 + RD);
        for (int l = 1; l <= ML + 3; l++) pulse(l, 1'b0);
        for (int l = 1; l <= AL + 3; l++) pulse(l, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule